// File: doc/BRIEF.md
# Word and Byte Arithmetic Unit with Operation-Specific Flags

This block executes one arithmetic operation at a time for an 8-bit accumulator processor. It can add, subtract or compare a 16-bit register pair against a 16-bit immediate. It can increment or decrement an 8-bit register, and it can increment or decrement a 16-bit register pair. The caller supplies an operation code, the operands and the present zero, auxiliary-carry and carry flags. The unit returns a result, a write strobe and the next flag values.

Each operation has its own rule for which flags it updates. Word add, subtract and compare update all three flags. Byte increment and decrement keep the carry flag. Pair increment and decrement change no flags. Compare never writes a result.

A small sequencer reproduces the fixed cycle cost of each operation and signals completion with a single-cycle `done` pulse. The caller takes the result, the strobe and the flags in that cycle.

Top module: `arith_unit`

## Requirements
- R1: Operation codes on `op` are: 0 no-op, 1 word add, 2 word subtract, 3 word compare, 4 byte increment, 5 byte decrement, 6 pair increment, 7 pair decrement. `start` is accepted only while `busy` is low. A `start` seen while `busy` is high is ignored and does not alter the operation in progress.
- R2: Word add produces `result` = (`pair_in` + `imm_in`) mod 65536 and raises `wr_en`. `cy_out` is the carry out of bit 15.
- R3: Word subtract produces `result` = (`pair_in` − `imm_in`) mod 65536 and raises `wr_en`. `cy_out` is 1 exactly when `pair_in` < `imm_in` as unsigned numbers.
- R4: Word compare keeps `wr_en` low. Its flags equal those that subtract would give for the same operands.
- R5: For word add, `ac_out` is the carry out of bit 3 of the operand sum. For word subtract and compare, `ac_out` is 1 when `pair_in[3:0]` < `imm_in[3:0]`.
- R6: For the three word operations, `z_out` is 1 exactly when the 16-bit difference or sum is zero.
- R7: Byte increment and decrement compute `byte_in` ± 1 mod 256 into `result[7:0]`, with `result[15:8]` = 0, and raise `wr_en`. `z_out` reflects the 8-bit value. `ac_out` is 1 when the low nibble of `byte_in` was 1111 (increment) or 0000 (decrement). `cy_out` equals `cy_in`.
- R8: Pair increment and decrement compute `pair_in` ± 1 mod 65536 and raise `wr_en`. All three flag outputs equal the flag inputs.
- R9: Counting the cycle in which `start` is accepted as cycle 0, `done` is high in cycle N−1 only. N is 6 for word operations, 2 for byte operations and the no-op, and 4 for pair operations.
- R10: The no-op keeps `wr_en` low and returns the flag inputs unchanged.
- R11: After synchronous reset, `busy`, `done`, `wr_en`, `result` and all flag outputs are 0.
- R12: `result` and the flag outputs keep their value from acceptance until the next accepted `start`. `wr_en` is high only in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code |
| pair_in | input | 16 | Register pair operand |
| imm_in | input | 16 | Immediate word operand |
| byte_in | input | 8 | Byte register operand |
| z_in | input | 1 | Current zero flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| cy_in | input | 1 | Current carry flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| wr_en | output | 1 | Result must be written back (done cycle only) |
| result | output | 16 | Operation result |
| z_out | output | 1 | Next zero flag |
| ac_out | output | 1 | Next auxiliary-carry flag |
| cy_out | output | 1 | Next carry flag |

## Verification
Two kinds of internal fault show up at the ports, and at different times.

A wrong latched operation code or flag snapshot shows up in the `done` cycle. It appears as a wrong `wr_en`, a wrong flag, or a carry that changed when it should have been kept. A wrong count in the sequencer moves the `done` pulse, so the pulse arrives a cycle early or late.

A `start` that is wrongly taken while busy changes `result` within one cycle, before the pending `done`. Each operation is observed cycle by cycle from acceptance up to one cycle after completion. This exposes both kinds of fault within at most six cycles of the fault.

// File: rtl/au_pkg.sv
package au_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 3'd0,
        OP_ADDW = 3'd1,
        OP_SUBW = 3'd2,
        OP_CMPW = 3'd3,
        OP_INC8 = 3'd4,
        OP_DEC8 = 3'd5,
        OP_INCW = 3'd6,
        OP_DECW = 3'd7
    } op_e;

    typedef struct packed {
        logic z;
        logic ac;
        logic cy;
    } flags_t;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              wr;
        flags_t            fl;
    } res_t;

    typedef enum logic [1:0] {
        CLS_WORD,
        CLS_BYTE,
        CLS_PAIR
    } cls_e;

    function automatic cls_e op_class(input op_e op);
        case (op)
            OP_ADDW, OP_SUBW, OP_CMPW: return CLS_WORD;
            OP_INCW, OP_DECW:          return CLS_PAIR;
            default:                   return CLS_BYTE;
        endcase
    endfunction

    function automatic logic nib_carry(input logic [3:0] a, input logic [3:0] b);
        logic [4:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[4];
    endfunction

endpackage

// File: rtl/au_core.sv
module au_core
    import au_pkg::*;
(
    input  op_e                op,
    input  logic [WORD_W-1:0]  pair,
    input  logic [WORD_W-1:0]  imm,
    input  logic [BYTE_W-1:0]  byte_v,
    input  flags_t             fin,
    output res_t               res
);

    logic [WORD_W:0]   sum_ext;
    logic [WORD_W-1:0] diff;
    logic              borrow;
    logic              nib_borrow;
    logic [BYTE_W-1:0] byte_up;
    logic [BYTE_W-1:0] byte_dn;

    assign sum_ext    = {1'b0, pair} + {1'b0, imm};
    assign diff       = pair - imm;
    assign borrow     = pair < imm;
    assign nib_borrow = pair[3:0] < imm[3:0];
    assign byte_up    = byte_v + 1'b1;
    assign byte_dn    = byte_v - 1'b1;

    always_comb begin
        res    = '0;
        res.fl = fin;
        case (op)
            OP_ADDW: begin
                res.value = sum_ext[WORD_W-1:0];
                res.wr    = 1'b1;
                res.fl.cy = sum_ext[WORD_W];
                res.fl.ac = nib_carry(pair[3:0], imm[3:0]);
                res.fl.z  = (sum_ext[WORD_W-1:0] == '0);
            end
            OP_SUBW, OP_CMPW: begin
                res.value = diff;
                res.wr    = (op == OP_SUBW);
                res.fl.cy = borrow;
                res.fl.ac = nib_borrow;
                res.fl.z  = (diff == '0);
            end
            OP_INC8: begin
                res.value = {{(WORD_W-BYTE_W){1'b0}}, byte_up};
                res.wr    = 1'b1;
                res.fl.ac = (byte_v[3:0] == 4'hF);
                res.fl.z  = (byte_up == '0);
            end
            OP_DEC8: begin
                res.value = {{(WORD_W-BYTE_W){1'b0}}, byte_dn};
                res.wr    = 1'b1;
                res.fl.ac = (byte_v[3:0] == 4'h0);
                res.fl.z  = (byte_dn == '0);
            end
            OP_INCW: begin
                res.value = pair + 1'b1;
                res.wr    = 1'b1;
            end
            OP_DECW: begin
                res.value = pair - 1'b1;
                res.wr    = 1'b1;
            end
            default: begin
                res.value = '0;
                res.wr    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/au_seq.sv
module au_seq #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] lat,
    output logic          accept,
    output logic          busy,
    output logic          done
);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign accept = start && !busy_q;
    assign busy   = busy_q;
    assign done   = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= lat - CW'(2);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // elapsed-cycle counter used only by the latency check
    logic [CW-1:0] elapsed_q;
    logic [CW-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed_q <= '0;
            lat_q     <= '0;
        end else if (accept) begin
            elapsed_q <= CW'(1);
            lat_q     <= lat;
        end else if (busy_q) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |=> busy_q);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (elapsed_q == lat_q - CW'(1)));

endmodule

// File: rtl/arith_unit.sv
module arith_unit
    import au_pkg::*;
#(
    parameter int LAT_WORD = 6,
    parameter int LAT_BYTE = 2,
    parameter int LAT_PAIR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] pair_in,
    input  logic [WORD_W-1:0] imm_in,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              z_in,
    input  logic              ac_in,
    input  logic              cy_in,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic [WORD_W-1:0] result,
    output logic              z_out,
    output logic              ac_out,
    output logic              cy_out
);

    localparam int LAT_MAX = (LAT_WORD > LAT_PAIR)
                           ? ((LAT_WORD > LAT_BYTE) ? LAT_WORD : LAT_BYTE)
                           : ((LAT_PAIR > LAT_BYTE) ? LAT_PAIR : LAT_BYTE);
    localparam int CW = $clog2(LAT_MAX + 1);

    op_e           op_now;
    flags_t        fl_now;
    res_t          core_res;
    logic [CW-1:0] lat_sel;
    logic          accept;

    op_e           op_q;
    flags_t        fin_q;
    res_t          res_q;

    assign op_now = op_e'(op);
    assign fl_now = '{z: z_in, ac: ac_in, cy: cy_in};

    au_core u_core (
        .op     (op_now),
        .pair   (pair_in),
        .imm    (imm_in),
        .byte_v (byte_in),
        .fin    (fl_now),
        .res    (core_res)
    );

    always_comb begin
        case (op_class(op_now))
            CLS_WORD: lat_sel = CW'(LAT_WORD);
            CLS_PAIR: lat_sel = CW'(LAT_PAIR);
            default:  lat_sel = CW'(LAT_BYTE);
        endcase
    end

    au_seq #(.CW(CW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .lat    (lat_sel),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_NOP;
            fin_q <= '0;
            res_q <= '0;
        end else if (accept) begin
            op_q  <= op_now;
            fin_q <= fl_now;
            res_q <= core_res;
        end
    end

    assign result = res_q.value;
    assign wr_en  = done && res_q.wr;
    assign z_out  = res_q.fl.z;
    assign ac_out = res_q.fl.ac;
    assign cy_out = res_q.fl.cy;

    assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OP_CMPW) |-> !wr_en);

    assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OP_NOP) |-> (!wr_en && {z_out, ac_out, cy_out} == fin_q));

    assert_byte_keep_cy_R7: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == OP_INC8 || op_q == OP_DEC8)) |-> (cy_out == fin_q.cy));

    assert_pair_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == OP_INCW || op_q == OP_DECW)) |-> ({z_out, ac_out, cy_out} == fin_q));

    assert_word_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == OP_ADDW || op_q == OP_SUBW || op_q == OP_CMPW))
            |-> (z_out == (result == '0)));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(result) && $stable(cy_out) && $stable(z_out)));

endmodule

// File: tb/arith_unit_tb_top.sv
`timescale 1ns/1ps
module arith_unit_tb_top;
    import au_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic [15:0] pair_in, imm_in;
    logic [7:0]  byte_in;
    logic        z_in, ac_in, cy_in;
    logic        busy, done, wr_en;
    logic [15:0] result;
    logic        z_out, ac_out, cy_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    arith_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .pair_in(pair_in), .imm_in(imm_in), .byte_in(byte_in),
        .z_in(z_in), .ac_in(ac_in), .cy_in(cy_in),
        .busy(busy), .done(done), .wr_en(wr_en), .result(result),
        .z_out(z_out), .ac_out(ac_out), .cy_out(cy_out)
    );

    typedef struct {
        logic [15:0] value;
        logic        wr;
        logic [2:0]  fl;
        int          lat;
        string       tag;
    } exp_t;

    function automatic exp_t model(input int code, input logic [15:0] p,
                                   input logic [15:0] m, input logic [7:0] b,
                                   input logic [2:0] f);
        exp_t e;
        logic [16:0] s;
        logic [7:0]  r8;
        e.value = 16'h0; e.wr = 1'b0; e.fl = f; e.lat = 2; e.tag = "R10";
        case (code)
            1: begin
                s = {1'b0, p} + {1'b0, m};
                e.value = s[15:0]; e.wr = 1'b1; e.lat = 6; e.tag = "R2";
                e.fl = {s[15:0] == 16'h0, (p[3:0] + m[3:0]) > 15, s[16]};
            end
            2, 3: begin
                e.value = p - m; e.wr = (code == 2); e.lat = 6;
                e.tag = (code == 2) ? "R3" : "R4";
                e.fl = {p == m, p[3:0] < m[3:0], p < m};
            end
            4, 5: begin
                r8 = (code == 4) ? b + 8'd1 : b - 8'd1;
                e.value = {8'h00, r8}; e.wr = 1'b1; e.lat = 2; e.tag = "R7";
                e.fl = {r8 == 8'h0, (code == 4) ? (b[3:0] == 4'hF) : (b[3:0] == 4'h0), f[0]};
            end
            6, 7: begin
                e.value = (code == 6) ? p + 16'd1 : p - 16'd1;
                e.wr = 1'b1; e.lat = 4; e.tag = "R8";
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input int code, input logic [15:0] p, input logic [15:0] m,
                          input logic [7:0] b, input logic [2:0] f, input bit junk);
        exp_t e;
        logic [15:0] held;
        e = model(code, p, m, b, f);
        @(negedge clk);
        op = 3'(code); pair_in = p; imm_in = m; byte_in = b;
        {z_in, ac_in, cy_in} = f; start = 1'b1;
        @(negedge clk);
        start = junk;
        if (junk) begin
            op = 3'd1; pair_in = ~p; imm_in = 16'h1357; byte_in = ~b; {z_in, ac_in, cy_in} = ~f;
        end
        for (int k = 1; k <= e.lat; k++) begin
            if (k > 1) @(negedge clk);
            if (k == 2) start = 1'b0;
            if (k == e.lat - 1) begin
                check(done == 1'b1, "R9", "done at completion", 32'(done), 1);
                check(result == e.value, junk ? "R1" : e.tag, "result", 32'(result), 32'(e.value));
                check(wr_en == e.wr, e.tag, "wr_en", 32'(wr_en), 32'(e.wr));
                check({z_out, ac_out, cy_out} == e.fl, (code >= 1 && code <= 3) ? "R5" : e.tag,
                      "flags z/ac/cy", 32'({z_out, ac_out, cy_out}), 32'(e.fl));
                held = result;
            end else if (k < e.lat - 1) begin
                check(done == 1'b0, "R9", "early done", 32'(done), 0);
            end else begin
                check(done == 1'b0 && wr_en == 1'b0, "R12", "done/wr_en after pulse",
                      32'({done, wr_en}), 0);
                check(result == held && {z_out, ac_out, cy_out} == e.fl, "R12",
                      "held outputs", 32'(result), 32'(held));
            end
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; op = 3'd0; pair_in = '0; imm_in = '0; byte_in = '0;
        z_in = 1'b0; ac_in = 1'b0; cy_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check({busy, done, wr_en, result, z_out, ac_out, cy_out} == '0, "R11",
              "reset state", 32'({busy, done, wr_en, result}), 0);

        // directed corners
        run_op(1, 16'hFFFF, 16'h0001, 8'h00, 3'b000, 0); // R2 wrap, zero, carry, aux carry
        run_op(1, 16'h000F, 16'h0001, 8'h00, 3'b101, 0); // R5 aux carry only
        run_op(1, 16'h1200, 16'h0034, 8'h00, 3'b111, 0); // R6 flags cleared
        run_op(2, 16'h1234, 16'h1234, 8'h00, 3'b000, 0); // R6 zero on subtract
        run_op(2, 16'h0000, 16'h0001, 8'h00, 3'b000, 0); // R3 borrow
        run_op(3, 16'h0010, 16'h0001, 8'h00, 3'b000, 0); // R4 compare, nibble borrow
        run_op(4, 16'h0000, 16'h0000, 8'hFF, 3'b001, 0); // R7 wrap to zero, cy kept
        run_op(4, 16'h0000, 16'h0000, 8'h0F, 3'b000, 0); // R7 nibble carry
        run_op(5, 16'h0000, 16'h0000, 8'h00, 3'b001, 0); // R7 wrap to FF
        run_op(5, 16'h0000, 16'h0000, 8'h01, 3'b000, 0); // R7 zero result
        run_op(6, 16'hFFFF, 16'h0000, 8'h00, 3'b010, 0); // R8 wrap, flags untouched
        run_op(7, 16'h0000, 16'h0000, 8'h00, 3'b101, 0); // R8 wrap down
        run_op(0, 16'hAAAA, 16'h5555, 8'h33, 3'b110, 0); // R10 no-op
        run_op(2, 16'h4321, 16'h0123, 8'h00, 3'b000, 1); // R1 start while busy ignored
        run_op(5, 16'h0000, 16'h0000, 8'h80, 3'b001, 1); // R1 on short latency
        run_op(6, 16'h7FFF, 16'h0000, 8'h00, 3'b111, 1); // R1 on pair op

        // constrained random
        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            int code;
            logic [15:0] p, m;
            code = int'($urandom_range(0, 7));
            p = 16'($urandom);
            m = ($urandom_range(0, 3) == 0) ? p : 16'($urandom);
            run_op(code, p, m, 8'($urandom), 3'($urandom), ($urandom_range(0, 7) == 0));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule